// File: doc/BRIEF.md
# Excess-One Carry Select Adder

This block adds two 16-bit operands and a carry-in, returning a 16-bit sum and a carry-out. It is purely combinational. The operand is cut into five groups of increasing width. The lowest group is a ripple-carry adder fed by the real carry-in.

Every higher group runs one ripple-carry adder with its carry-in tied to zero. An increment-by-one converter then turns that result into the answer for a carry-in of one. The group's carry-out is taken as the top bit of both results. A two-way select, steered by the carry arriving from the group below, picks the result.

The block drops into any datapath that needs a plain unsigned add. It uses less hardware than a carry select adder that duplicates every ripple chain.

Top module: `xs1_csel_add`

## Requirements
- R1: For all inputs, {co, sum} equals a + b + ci computed as a 17-bit unsigned value.
- R2: The least significant group covers bits 1:0 and uses the real carry-in; with a = b = 0 and ci = 1 the sum is 0x0001 and co is 0.
- R3: Each higher group forms its carry-in-zero result with a ripple-carry adder whose carry-in is fixed at 0. With ci = 0, operands that produce no carry across a group boundary give the plain bitwise sum of each group.
- R4: A group's carry-in-one result is its carry-in-zero result, with the group carry-out as top bit, plus one. An all-ones group fed a carry of one therefore rolls to zero and carries out; for example, a = 0xFFFF, b = 0, ci = 1 gives sum 0x0000 and co 1.
- R5: The carry-out of the group below selects between a group's two results: 1 selects the incremented result and 0 selects the zero-carry result.
- R6: Group widths from least to most significant are 2, 2, 3, 4 and 5 bits, so the group boundaries sit below bits 2, 4, 7 and 11. A carry generated just under any boundary reaches the bit above it.
- R7: co is the carry-out of the most significant group; 0xFFFF + 0x0001 gives sum 0x0000 and co 1, and 0xFFFF + 0xFFFF + 1 gives sum 0xFFFF and co 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand, unsigned |
| b | input | 16 | Second operand, unsigned |
| ci | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + ci |
| co | output | 1 | Carry out of bit 15 |

## Verification
The in-module assertions assume that the operands and carry-in are known two-state values. They also assume each checking process sees a consistent set of inputs, so the ripple and increment relations hold whenever a process evaluates.

One of them relies on a property of the add itself: a zero-carry group result can never be all ones, so the converter never wraps inside a group.

The stimulus drives only 0 and 1 levels. It holds every vector steady for a nanosecond before the outputs are sampled, well inside half a clock period. It sweeps the lower eight bits of both operands exhaustively while rotating the upper bits through fixed patterns, then runs pseudo-random vectors and carries placed at each group boundary.

// File: rtl/xs1_add_pkg.sv
package xs1_add_pkg;

    localparam int NGRP = 5;

    // width of group g, least significant first
    function automatic int grp_width(input int g);
        case (g)
            0:       return 2;
            1:       return 2;
            2:       return 3;
            3:       return 4;
            default: return 5;
        endcase
    endfunction

    // lowest bit index of group g
    function automatic int grp_lsb(input int g);
        int acc;
        acc = 0;
        for (int k = 0; k < g; k++) acc += grp_width(k);
        return acc;
    endfunction

    localparam int DATA_W = grp_lsb(NGRP);

endpackage

// File: rtl/xs1_rca.sv
module xs1_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0]   carry_d;
    logic [W-1:0] s_d;

    always_comb begin
        carry_d[0] = ci;
        for (int i = 0; i < W; i++) begin
            s_d[i]       = a[i] ^ b[i] ^ carry_d[i];
            carry_d[i+1] = (a[i] & b[i]) | (carry_d[i] & (a[i] ^ b[i]));
        end
        // R3: chained full adders agree with arithmetic addition
        p_ripple_sum_r3: assert ({carry_d[W], s_d} ==
                                 ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}))
            else $error("ripple chain disagrees with a+b+ci");
    end

    assign s  = s_d;
    assign co = carry_d[W];
endmodule

// File: rtl/xs1_inc_conv.sv
module xs1_inc_conv #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    logic [W-1:0] y_d;
    logic         all1_d;

    always_comb begin
        all1_d = 1'b1;
        for (int i = 0; i < W; i++) begin
            y_d[i] = x[i] ^ all1_d;
            all1_d = all1_d & x[i];
        end
        // R4: toggle network equals increment by one (modulo 2^W)
        p_conv_inc_r4: assert (y_d == x + {{(W-1){1'b0}}, 1'b1})
            else $error("converter output is not input plus one");
        // R4: bit 0 always flips
        p_conv_lsb_r4: assert (y_d[0] != x[0])
            else $error("converter lsb did not flip");
    end

    assign y = y_d;
endmodule

// File: rtl/xs1_csel_group.sv
module xs1_csel_group #(
    parameter int W      = 4,
    parameter bit IS_LOW = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    generate
        if (IS_LOW) begin : g_low
            xs1_rca #(.W(W)) u_rca (
                .a (a), .b (b), .ci (ci), .s (s), .co (co)
            );
        end else begin : g_sel
            logic [W-1:0] s0_d;
            logic         c0_d;
            logic [W:0]   zc_d;
            logic [W:0]   oc_d;

            xs1_rca #(.W(W)) u_rca (
                .a (a), .b (b), .ci (1'b0), .s (s0_d), .co (c0_d)
            );

            assign zc_d = {c0_d, s0_d};

            xs1_inc_conv #(.W(W+1)) u_conv (
                .x (zc_d), .y (oc_d)
            );

            always_comb begin
                // R4: a sum of two W-bit values never fills W+1 ones,
                // so the converter never wraps inside a group
                p_zc_headroom_r4: assert (zc_d != {(W+1){1'b1}})
                    else $error("zero-carry result is all ones");
            end

            // R5: carry from the group below steers the select
            assign {co, s} = ci ? oc_d : zc_d;
        end
    endgenerate
endmodule

// File: rtl/xs1_csel_add.sv
module xs1_csel_add
    import xs1_add_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              ci,
    output logic [DATA_W-1:0] sum,
    output logic              co
);
    logic [NGRP:0] gc_d;

    assign gc_d[0] = ci;

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            localparam int LSB = grp_lsb(g);
            localparam int GW  = grp_width(g);
            xs1_csel_group #(.W(GW), .IS_LOW(g == 0)) u_grp (
                .a  (a[LSB +: GW]),
                .b  (b[LSB +: GW]),
                .ci (gc_d[g]),
                .s  (sum[LSB +: GW]),
                .co (gc_d[g+1])
            );
        end
    endgenerate

    // R7: carry-out comes from the top group
    assign co = gc_d[NGRP];
endmodule

// File: tb/sim_xs1_csel_add.sv
`timescale 1ns/1ps
module sim_xs1_csel_add;
    logic        clk = 1'b0;
    logic [15:0] a = '0, b = '0;
    logic        ci = 1'b0;
    logic [15:0] sum;
    logic        co;
    int          n_chk = 0, n_fail = 0, cyc = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    xs1_csel_add u0 (.a(a), .b(b), .ci(ci), .sum(sum), .co(co));

    task automatic apply(input string tag, input logic [15:0] va,
                         input logic [15:0] vb, input logic vc);
        logic [16:0] exp_v;
        a = va; b = vb; ci = vc;
        #1;
        exp_v = {1'b0, va} + {1'b0, vb} + {16'b0, vc};
        n_chk++;
        if ({co, sum} !== exp_v) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h ci=%b got co=%b sum=%h exp co=%b sum=%h",
                     tag, va, vb, vc, co, sum, exp_v[16], exp_v[15:0]);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf1, lf2;
        int bnd [5];
        bnd[0] = 2; bnd[1] = 4; bnd[2] = 7; bnd[3] = 11; bnd[4] = 16;
        #2;
        apply("R1", 16'h0000, 16'h0000, 1'b0);      // idle state
        apply("R2", 16'h0000, 16'h0000, 1'b1);
        apply("R2", 16'h0001, 16'h0002, 1'b1);
        apply("R3", 16'h0124, 16'h0210, 1'b0);      // no cross-group carries
        apply("R3", 16'h4a52, 16'h1084, 1'b0);
        apply("R4", 16'hFFFF, 16'h0000, 1'b1);
        apply("R7", 16'hFFFF, 16'h0001, 1'b0);
        apply("R7", 16'hFFFF, 16'hFFFF, 1'b1);
        apply("R7", 16'hFFFF, 16'hFFFF, 1'b0);
        // R6 / R5: carries generated or propagated at every boundary
        for (int k = 0; k < 5; k++) begin
            logic [16:0] m;
            m = (17'd1 << bnd[k]) - 17'd1;
            apply("R6", m[15:0], 16'h0001, 1'b0);
            apply("R5", m[15:0], 16'h0000, 1'b1);
            apply("R6", 16'(1 << (bnd[k] - 1)), 16'(1 << (bnd[k] - 1)), 1'b0);
        end
        // R1: exhaustive low byte, rotating upper patterns
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [7:0] ha, hb;
                    case ((i + j) % 4)
                        0: begin ha = 8'h00; hb = 8'h00; end
                        1: begin ha = 8'hFF; hb = 8'h00; end
                        2: begin ha = 8'h80; hb = 8'h7F; end
                        default: begin ha = 8'hFF; hb = 8'hFF; end
                    endcase
                    apply("R1", {ha, 8'(i)}, {hb, 8'(j)}, c[0]);
                end
            end
        end
        // R1: pseudo-random vectors from two LFSRs
        lf1 = 16'hACE1; lf2 = 16'h1D2B;
        for (int n = 0; n < 20000; n++) begin
            lf1 = {lf1[14:0], lf1[15] ^ lf1[13] ^ lf1[12] ^ lf1[10]};
            lf2 = {lf2[14:0], lf2[15] ^ lf2[13] ^ lf2[12] ^ lf2[10]};
            apply("R1", lf1, lf2, lf1[3] ^ lf2[7]);
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule